// File: doc/BRIEF.md
# Watchdog and Stop-Mode Controller

This block holds a small controller's supervision timer and its low-power stop sequencer. A prescaler divides the free-running oscillator clock down to the instruction rate, selectable as 1/6 or 1/48. A binary watchdog counter advances once per instruction tick. If nothing clears it in time, it overflows and raises a CPU reset that lasts one instruction tick. Software clears it with a dedicated clear strobe. When an option pin allows, writes to the carrier output also clear it.

A stop strobe parks the controller. The oscillator enable drops, instruction execution is blocked, and the two upper D outputs and the carrier output are forced low. The lower D outputs are also forced low when their option pin is set. A low level on any release input whose mask bit is set wakes the block. The oscillator then runs for a fixed settling count before instructions may resume. If an enabled release input is already low when stop is requested, the request has no effect. The watchdog stays at zero from stop entry until the block resumes.

The block has no data stream, so every pin is a plain level or strobe.

Top module: `wdt_stop_ctrl`

## Requirements
- R1: After reset, run_en=1, osc_en=1, cpu_rst=0, hi_carrier_low=0 and lower_force_low=0.
- R2: While running, the watchdog advances once every FAST_DIV clocks when slow_sel=0, and once every SLOW_DIV clocks when slow_sel=1.
- R3: After 2^(WDT_W-1) ticks with no clear, cpu_rst goes high for exactly one tick period (one prescaler period), and counting restarts from zero.
- R4: A wdt_clr_req pulse sets the count to zero. A clear that lands on the same clock as the overflowing tick wins, and no reset occurs.
- R5: A carrier_wr pulse clears the watchdog only while carrier_clr_en=1; otherwise it has no effect.
- R6: When stop_req is accepted, the next cycle has osc_en=0, run_en=0 and hi_carrier_low=1.
- R7: A stop_req that arrives while any input with rel_in=0 and rel_mask=1 exists is ignored, and run_en stays 1.
- R8: In stop, a low rel_in bit whose rel_mask bit is 1 starts settling (osc_en=1, run_en=0) on the next cycle. A low bit whose mask is 0 is ignored.
- R9: Settling lasts exactly SETTLE_CYC clocks, after which run_en=1.
- R10: The watchdog is zero throughout stop and settling. After resume, an overflow occurs exactly 2^(WDT_W-1) ticks later.
- R11: lower_force_low=1 exactly when the block is not running and lower_low_opt=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_sel | input | 1 | 1 selects the 1/48 instruction rate, 0 selects 1/6 |
| wdt_clr_req | input | 1 | Watchdog clear strobe |
| carrier_wr | input | 1 | Carrier-output write strobe |
| carrier_clr_en | input | 1 | Option: carrier writes clear the watchdog |
| stop_req | input | 1 | Stop instruction strobe |
| rel_in | input | N_REL | Key and I/O input levels |
| rel_mask | input | N_REL | Per-bit release enable |
| lower_low_opt | input | 1 | Option: force the lower D outputs low in stop |
| osc_en | output | 1 | Oscillator enable |
| run_en | output | 1 | Instructions may execute |
| cpu_rst | output | 1 | Watchdog reset pulse |
| hi_carrier_low | output | 1 | Force the upper D outputs and the carrier output low |
| lower_force_low | output | 1 | Force the lower D outputs low |

## Verification
Two functions can meet on the same edge: the overflowing watchdog tick and a clear strobe. The bench counts clocks from reset and raises wdt_clr_req precisely on the clock of the overflowing tick. It then expects no reset pulse, and expects the next overflow a full window later. A second collision is a stop request made while an enabled release input is already low. Here the request must be dropped, and the watchdog must keep counting. A behavioural reference model is compared against every output on every clock.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_SETTLE = 2'd2
  } wsc_state_e;
endpackage

// File: rtl/wsc_prescale.sv
module wsc_prescale #(
  parameter int FAST_DIV = 6,
  parameter int SLOW_DIV = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic slow_sel,
  output logic tick
);
  localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW   = $clog2(MAXD + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim;

  assign lim  = slow_sel ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
  assign tick = !hold && (pre_q >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pre_q <= '0;
    else if (hold || tick) pre_q <= '0;
    else                   pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wsc_watchdog.sv
module wsc_watchdog #(
  parameter int WDT_W = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic tick,
  input  logic clr,
  output logic cpu_rst
);
  localparam int LIMIT = 1 << (WDT_W - 1);

  logic [WDT_W-1:0] cnt_q;
  logic             rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else if (hold) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (tick && rst_q) rst_q <= 1'b0;
      if (clr || rst_q) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == WDT_W'(LIMIT - 1)) begin
          cnt_q <= '0;
          rst_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cpu_rst = rst_q;
endmodule

// File: rtl/wsc_stop_fsm.sv
module wsc_stop_fsm
  import wsc_pkg::*;
#(
  parameter int N_REL      = 8,
  parameter int SETTLE_CYC = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_req,
  input  logic [N_REL-1:0] rel_in,
  input  logic [N_REL-1:0] rel_mask,
  output wsc_state_e       state,
  output logic             go_stop
);
  localparam int SW = $clog2(SETTLE_CYC + 1);

  logic [N_REL-1:0] wake_bit;
  logic             wake;
  wsc_state_e       st_q;
  logic [SW-1:0]    scnt_q;

  for (genvar i = 0; i < N_REL; i++) begin : g_wake
    assign wake_bit[i] = rel_mask[i] & ~rel_in[i];
  end
  assign wake    = |wake_bit;
  assign go_stop = (st_q == ST_RUN) && stop_req && !wake;
  assign state   = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_RUN;
      scnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_RUN: if (go_stop) st_q <= ST_STOP;
        ST_STOP: if (wake) begin
          st_q   <= ST_SETTLE;
          scnt_q <= '0;
        end
        ST_SETTLE: begin
          if (scnt_q == SW'(SETTLE_CYC - 1)) st_q <= ST_RUN;
          else scnt_q <= scnt_q + 1'b1;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/wdt_stop_ctrl.sv
module wdt_stop_ctrl
  import wsc_pkg::*;
#(
  parameter int WDT_W      = 14,
  parameter int FAST_DIV   = 6,
  parameter int SLOW_DIV   = 48,
  parameter int SETTLE_CYC = 8192,
  parameter int N_REL      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_sel,
  input  logic             wdt_clr_req,
  input  logic             carrier_wr,
  input  logic             carrier_clr_en,
  input  logic             stop_req,
  input  logic [N_REL-1:0] rel_in,
  input  logic [N_REL-1:0] rel_mask,
  input  logic             lower_low_opt,
  output logic             osc_en,
  output logic             run_en,
  output logic             cpu_rst,
  output logic             hi_carrier_low,
  output logic             lower_force_low
);
  wsc_state_e state;
  logic       go_stop, hold, tick, clr;

  assign hold = (state != ST_RUN) || go_stop;
  assign clr  = wdt_clr_req || (carrier_clr_en && carrier_wr);

  wsc_stop_fsm #(.N_REL(N_REL), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rel_in(rel_in),
    .rel_mask(rel_mask), .state(state), .go_stop(go_stop)
  );

  wsc_prescale #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(hold), .slow_sel(slow_sel), .tick(tick)
  );

  wsc_watchdog #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick), .clr(clr),
    .cpu_rst(cpu_rst)
  );

  assign run_en          = (state == ST_RUN);
  assign osc_en          = (state != ST_STOP);
  assign hi_carrier_low  = (state != ST_RUN);
  assign lower_force_low = (state != ST_RUN) && lower_low_opt;
endmodule

// File: rtl/wsc_checker.sv
module wsc_checker #(
  parameter int N_REL      = 8,
  parameter int SETTLE_CYC = 8192
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stop_req,
  input logic [N_REL-1:0] rel_in,
  input logic [N_REL-1:0] rel_mask,
  input logic             osc_en,
  input logic             run_en,
  input logic             cpu_rst,
  input logic             hi_carrier_low,
  input logic             lower_force_low
);
  int settle_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_seen <= 0;
    else if (osc_en && !run_en) settle_seen <= settle_seen + 1;
    else                        settle_seen <= 0;
  end

  a_r7_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && stop_req && (|(~rel_in & rel_mask)) |=> run_en);

  a_r6_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    run_en && stop_req && !(|(~rel_in & rel_mask)) |=> !osc_en && !run_en && hi_carrier_low);

  a_r8_wake_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> $past(|(~rel_in & rel_mask)));

  a_r9_settle_len: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> settle_seen == SETTLE_CYC);

  a_r3_rst_only_running: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> run_en);

  a_r11_lower_subset: assert property (@(posedge clk) disable iff (!rst_n)
    lower_force_low |-> hi_carrier_low);
endmodule

bind wdt_stop_ctrl wsc_checker #(.N_REL(N_REL), .SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .rel_in(rel_in),
  .rel_mask(rel_mask), .osc_en(osc_en), .run_en(run_en), .cpu_rst(cpu_rst),
  .hi_carrier_low(hi_carrier_low), .lower_force_low(lower_force_low)
);

// File: tb/wdt_stop_ctrl_bench.sv
module wdt_stop_ctrl_bench;
  localparam int W = 6, SET = 64, NR = 8, FD = 6, SD = 48;
  localparam int LIMIT = 1 << (W - 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic slow_sel = 0, wdt_clr_req = 0, carrier_wr = 0, carrier_clr_en = 0;
  logic stop_req = 0, lower_low_opt = 0;
  logic [NR-1:0] rel_in = '1, rel_mask = '0;
  logic osc_en, run_en, cpu_rst, hi_carrier_low, lower_force_low;

  int total = 0, bad = 0;

  always #10 clk = ~clk;

  wdt_stop_ctrl #(.WDT_W(W), .FAST_DIV(FD), .SLOW_DIV(SD), .SETTLE_CYC(SET), .N_REL(NR))
  u_wdt_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .wdt_clr_req(wdt_clr_req),
    .carrier_wr(carrier_wr), .carrier_clr_en(carrier_clr_en), .stop_req(stop_req),
    .rel_in(rel_in), .rel_mask(rel_mask), .lower_low_opt(lower_low_opt),
    .osc_en(osc_en), .run_en(run_en), .cpu_rst(cpu_rst),
    .hi_carrier_low(hi_carrier_low), .lower_force_low(lower_force_low)
  );

  // Reference model: mode 0 running, 1 stopped, 2 settling
  int m_mode, m_pre, m_cnt, m_scnt, m_div;
  bit m_rst, m_old, m_tick, m_low, m_clr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_pre = 0; m_cnt = 0; m_scnt = 0; m_rst = 0;
    end else begin
      m_div  = slow_sel ? SD : FD;
      m_low  = |(~rel_in & rel_mask);
      m_clr  = wdt_clr_req | (carrier_clr_en & carrier_wr);
      if (m_mode == 0) begin
        m_tick = (m_pre >= m_div - 1);
        if (stop_req && !m_low) begin
          m_mode = 1; m_pre = 0; m_cnt = 0; m_rst = 0;
        end else begin
          m_pre = m_tick ? 0 : m_pre + 1;
          m_old = m_rst;
          if (m_tick && m_old) m_rst = 0;
          if (m_clr || m_old) m_cnt = 0;
          else if (m_tick) begin
            if (m_cnt == LIMIT - 1) begin m_cnt = 0; m_rst = 1; end
            else m_cnt = m_cnt + 1;
          end
        end
      end else if (m_mode == 1) begin
        if (m_low) begin m_mode = 2; m_scnt = 0; end
      end else begin
        if (m_scnt == SET - 1) m_mode = 0;
        else m_scnt = m_scnt + 1;
      end
    end
  end

  task automatic cmp(string tag, string nm, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      cmp("R9", "run_en", run_en, m_mode == 0);
      cmp("R6", "osc_en", osc_en, m_mode != 1);
      cmp("R3", "cpu_rst", cpu_rst, m_rst);
      cmp("R6", "hi_carrier_low", hi_carrier_low, m_mode != 0);
      cmp("R11", "lower_force_low", lower_force_low, (m_mode != 0) && lower_low_opt);
    end
  end

  task automatic chk(string tag, string nm, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wait_rst(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!cpu_rst && n < 5000);
  endtask

  initial begin : watchdog_timer
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    int n, w;
    do_reset();
    // R1 reset state
    chk("R1", "run_en", run_en, 1);
    chk("R1", "osc_en", osc_en, 1);
    chk("R1", "cpu_rst", cpu_rst, 0);
    chk("R1", "forces", {hi_carrier_low, lower_force_low}, 0);

    // R3 overflow timing at the fast rate, and pulse width
    wait_rst(n);
    chk("R3", "overflow clocks", n, LIMIT * FD);
    w = 0;
    while (cpu_rst && w < 1000) begin w++; @(negedge clk); end
    chk("R3", "pulse width", w, FD);

    // R2 slow rate
    slow_sel = 1;
    do_reset();
    wait_rst(n);
    chk("R2", "slow overflow clocks", n, LIMIT * SD);
    slow_sel = 0;

    // R4 clear mid-window
    do_reset();
    repeat (100) @(negedge clk);
    wdt_clr_req = 1; @(negedge clk); wdt_clr_req = 0;
    wait_rst(n);
    chk("R4", "overflow after clear", 101 + n, 288);

    // R4 clear on the overflowing tick
    do_reset();
    repeat (191) @(negedge clk);
    wdt_clr_req = 1; @(negedge clk); wdt_clr_req = 0;
    chk("R4", "no reset on collision", cpu_rst, 0);
    wait_rst(n);
    chk("R4", "overflow after collision", 192 + n, 384);

    // R5 carrier write ignored without option
    do_reset();
    repeat (100) @(negedge clk);
    carrier_wr = 1; @(negedge clk); carrier_wr = 0;
    wait_rst(n);
    chk("R5", "carrier write ignored", 101 + n, 192);
    // R5 carrier write clears with option
    carrier_clr_en = 1;
    do_reset();
    repeat (100) @(negedge clk);
    carrier_wr = 1; @(negedge clk); carrier_wr = 0;
    wait_rst(n);
    chk("R5", "carrier write clears", 101 + n, 288);
    carrier_clr_en = 0;

    // R7 stop with enabled input already low
    do_reset();
    rel_mask = 8'h01; rel_in = 8'hFE; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R7", "run_en stays", run_en, 1);
    chk("R7", "osc_en stays", osc_en, 1);

    // R6 and R11 stop entry
    rel_in = '1; lower_low_opt = 1; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R6", "osc_en off", osc_en, 0);
    chk("R6", "run_en off", run_en, 0);
    chk("R6", "hi_carrier_low", hi_carrier_low, 1);
    chk("R11", "lower low with option", lower_force_low, 1);

    // R8 masked-off input ignored
    rel_in = 8'hF7;
    repeat (5) @(negedge clk);
    chk("R8", "masked low ignored", osc_en, 0);
    rel_in = 8'hF6;
    @(negedge clk);
    chk("R8", "settle osc_en", osc_en, 1);
    chk("R8", "settle run_en", run_en, 0);

    // R9 settle length
    n = 0;
    while (!run_en && n < 1000) begin @(negedge clk); n++; end
    chk("R9", "settle clocks", n, SET);
    rel_in = '1;

    // R10 watchdog restarts from zero after resume
    wait_rst(n);
    chk("R10", "overflow after resume", n, LIMIT * FD);

    // R11 lower outputs keep levels without option
    repeat (10) @(negedge clk);
    lower_low_opt = 0; stop_req = 1;
    @(negedge clk); stop_req = 0;
    chk("R11", "lower kept without option", lower_force_low, 0);
    chk("R6", "upper forced", hi_carrier_low, 1);
    rel_in = 8'hFE;
    @(negedge clk); rel_in = '1;
    repeat (SET + 4) @(negedge clk);
    chk("R9", "resumed", run_en, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule